// File: doc/BRIEF.md
# Dual-View GPIO Register Bank

This block holds the output enable and output data state of up to 128 general-purpose pins and exposes it through a byte-wide register port in two ways. In the first view, every pin has its own byte: output enable, output data and the synchronised input level. In the second view, eight pins share one byte, and there are separate arrays for inputs, output data and output enables. Both views decode onto the same flops, so a write through either view is seen at once in the other.

Pin inputs pass through a two-flop synchroniser before either read view reports them. One designated pin (I/O 0x28 by default) can have its driven value replaced by one of two externally supplied clocks. A 2-bit selector made from the output-data bits of two other per-pin registers picks the source. Three read-only bytes identify the model and revision. The serial host bus and the pin-routing crossbar sit outside this block.

Top module: `gpio_dual_view`

## Requirements
- R1: After reset, every `pin_oe` and `pin_out` bit is 0, the override selector is 00, and `reg_rdata` is 0.
- R2: A write to address n (n < 128) sets pin n's output enable from data bit 0 and its output data from data bit 1, both in the same cycle. `pin_oe[n]` and `pin_out[n]` show the new values right after the writing clock edge.
- R3: A read of address n (n < 128) returns bit 0 = output enable, bit 1 = output data, bit 2 = synchronised input, and bits 7:3 = 0. The value appears on `reg_rdata` after the clock edge at which the address was presented.
- R4: Pin n lies in bank n/8 at bit n%8. A write to 0x110+b replaces the output data of pins 8b..8b+7 at once. A write to 0x120+b does the same for their output enables.
- R5: Reads of 0x100+b, 0x110+b and 0x120+b return the synchronised inputs, output data and output enables of pins 8b..8b+7. These agree with the per-pin view of the same pins.
- R6: A change on `pin_in` that is set up before clock edge k becomes visible in a read result at edge k+2, and not at edge k+1.
- R7: Writes to the input bank bytes (0x100–0x10F), the identification bytes, or any reserved address leave every output enable and output data bit unchanged.
- R8: Address 0x130 reads 0x41, 0x131 reads 0x00, and 0x132 reads the REVISION parameter. Addresses 0x080–0x0FF and 0x133–0x1FFF read 0.
- R9: The override selector is {output data of pin 0x57, output data of pin 0x58}. When it is 01, `pin_out[0x28]` follows `ovr_clk_a`. When it is 10 or 11, `pin_out[0x28]` follows `ovr_clk_b`. When it is 00, `pin_out[0x28]` carries that pin's output data.
- R10: Every pin other than 0x28 always drives its own output data on `pin_out`, whatever the override selector. The override never changes `pin_oe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 13 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered, for the address of the previous cycle |
| pin_in | input | 128 | Asynchronous pin input levels |
| pin_out | output | 128 | Pin output data (pin 0x28 may carry an override clock) |
| pin_oe | output | 128 | Pin output enables |
| ovr_clk_a | input | 1 | First override clock source |
| ovr_clk_b | input | 1 | Second override clock source |

## Verification
A wrong output enable or output data bit shows on `pin_oe` or `pin_out` in the first cycle after the write that set it. So the bench can compare every pin against the reference model on every clock. If the per-pin and banked decodes disagree about which flop a pin owns, the next read through the other view returns a byte that does not match the model, one cycle after the address is presented. A fault in the synchroniser depth moves the input bit in the read data by a whole cycle, which the per-cycle comparison catches at the edge where it first differs. A wrong override selector shows as `pin_out[0x28]` following the wrong clock while the two clocks toggle independently.

// File: rtl/gpio_dv_pkg.sv
package gpio_dv_pkg;

    localparam int ADDR_W = 13;

    localparam logic [8:0] PAGE_BANK_IN = 9'h010;
    localparam logic [8:0] PAGE_BANK_OD = 9'h011;
    localparam logic [8:0] PAGE_BANK_OE = 9'h012;

    localparam logic [ADDR_W-1:0] ADDR_ID_HI  = 13'h130;
    localparam logic [ADDR_W-1:0] ADDR_ID_LO  = 13'h131;
    localparam logic [ADDR_W-1:0] ADDR_ID_REV = 13'h132;

    localparam logic [7:0] MODEL_HI = 8'h41;
    localparam logic [7:0] MODEL_LO = 8'h00;

    typedef enum logic [2:0] {
        RGN_PIN,
        RGN_BANK_IN,
        RGN_BANK_OD,
        RGN_BANK_OE,
        RGN_ID,
        RGN_NONE
    } region_e;

    // Address decode shared by the write and read sides; npins must not exceed 128.
    function automatic region_e classify(input logic [ADDR_W-1:0] a, input int npins);
        region_e r;
        r = RGN_NONE;
        if (int'(a) < npins) begin
            r = RGN_PIN;
        end else if (int'(a[3:0]) < (npins / 8)) begin
            case (a[ADDR_W-1:4])
                PAGE_BANK_IN: r = RGN_BANK_IN;
                PAGE_BANK_OD: r = RGN_BANK_OD;
                PAGE_BANK_OE: r = RGN_BANK_OE;
                default:      r = RGN_NONE;
            endcase
        end
        if (a == ADDR_ID_HI || a == ADDR_ID_LO || a == ADDR_ID_REV) begin
            r = RGN_ID;
        end
        return r;
    endfunction

endpackage

// File: rtl/gpio_dv_sync.sv
module gpio_dv_sync #(
    parameter int WIDTH = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din_async,
    output logic [WIDTH-1:0] din_sync
);

    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = din_async;
        sy_d.s2 = sy_q.s1;
    end

    // Reset-free on purpose: the stages only ever carry the pin level.
    always_ff @(posedge clk) begin
        sy_q <= sy_d;
    end

    assign din_sync = sy_q.s2;

    // R6
    sync_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        din_sync == $past(din_async, 2));

endmodule

// File: rtl/gpio_dv_state.sv
module gpio_dv_state
    import gpio_dv_pkg::*;
#(
    parameter int NUM_PINS = 128,
    parameter int SEL_HI   = 87,
    parameter int SEL_LO   = 88
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [7:0]          wdata,
    output logic [NUM_PINS-1:0] oe_o,
    output logic [NUM_PINS-1:0] od_o,
    output logic [1:0]          sel_o
);

    localparam int PIN_W = $clog2(NUM_PINS);

    typedef struct packed {
        logic [NUM_PINS-1:0] oe;
        logic [NUM_PINS-1:0] od;
    } state_t;

    state_t      st_d, st_q;
    region_e     rgn;
    logic [PIN_W-1:0] pin_idx;
    int          bank_base;

    assign rgn       = classify(addr, NUM_PINS);
    assign pin_idx   = addr[PIN_W-1:0];
    assign bank_base = int'(addr[3:0]) * 8;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (rgn)
                RGN_PIN: begin
                    st_d.oe[pin_idx] = wdata[0];
                    st_d.od[pin_idx] = wdata[1];
                end
                RGN_BANK_OD: st_d.od[bank_base +: 8] = wdata;
                RGN_BANK_OE: st_d.oe[bank_base +: 8] = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign oe_o  = st_q.oe;
    assign od_o  = st_q.od;
    assign sel_o = {st_q.od[SEL_HI], st_q.od[SEL_LO]};

    // R2
    pin_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rgn == RGN_PIN) |=>
        (oe_o[$past(pin_idx)] == $past(wdata[0]) && od_o[$past(pin_idx)] == $past(wdata[1])));

    // R7
    ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (rgn == RGN_BANK_IN || rgn == RGN_ID || rgn == RGN_NONE)) |=>
        ($stable(oe_o) && $stable(od_o)));

endmodule

// File: rtl/gpio_dv_rdmux.sv
module gpio_dv_rdmux
    import gpio_dv_pkg::*;
#(
    parameter int          NUM_PINS = 128,
    parameter logic [7:0]  REVISION = 8'h01
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NUM_PINS-1:0] oe,
    input  logic [NUM_PINS-1:0] od,
    input  logic [NUM_PINS-1:0] din,
    output logic [7:0]          rdata_o
);

    localparam int PIN_W = $clog2(NUM_PINS);

    logic [7:0]       rd_d, rd_q;
    region_e          rgn;
    logic [PIN_W-1:0] pin_idx;
    int               bank_base;

    assign rgn       = classify(addr, NUM_PINS);
    assign pin_idx   = addr[PIN_W-1:0];
    assign bank_base = int'(addr[3:0]) * 8;

    always_comb begin
        rd_d = '0;
        case (rgn)
            RGN_PIN:     rd_d = {5'd0, din[pin_idx], od[pin_idx], oe[pin_idx]};
            RGN_BANK_IN: rd_d = din[bank_base +: 8];
            RGN_BANK_OD: rd_d = od[bank_base +: 8];
            RGN_BANK_OE: rd_d = oe[bank_base +: 8];
            RGN_ID: begin
                case (addr[1:0])
                    2'd0:    rd_d = MODEL_HI;
                    2'd1:    rd_d = MODEL_LO;
                    2'd2:    rd_d = REVISION;
                    default: rd_d = '0;
                endcase
            end
            default: rd_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata_o = rd_q;

    // R3
    pin_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rgn == RGN_PIN) |=> (rdata_o[7:3] == 5'd0));

    // R8
    ident_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_ID_HI) |=> (rdata_o == MODEL_HI));

    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rgn == RGN_NONE) |=> (rdata_o == 8'd0));

endmodule

// File: rtl/gpio_dv_clkovr.sv
module gpio_dv_clkovr (
    input  logic       od_i,
    input  logic [1:0] sel_i,
    input  logic       clk_a_i,
    input  logic       clk_b_i,
    output logic       pin_o
);

    always_comb begin
        case (sel_i)
            2'b00:   pin_o = od_i;
            2'b01:   pin_o = clk_a_i;
            default: pin_o = clk_b_i;
        endcase
    end

endmodule

// File: rtl/gpio_dual_view.sv
module gpio_dual_view
    import gpio_dv_pkg::*;
#(
    parameter int         NUM_PINS = 128,
    parameter int         OVR_PIN  = 40,
    parameter int         SEL_HI   = 87,
    parameter int         SEL_LO   = 88,
    parameter logic [7:0] REVISION = 8'h01
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [12:0]         reg_addr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    input  logic                ovr_clk_a,
    input  logic                ovr_clk_b
);

    localparam int NUM_BANKS = NUM_PINS / 8;

    logic [NUM_PINS-1:0] din_sync;
    logic [NUM_PINS-1:0] od;
    logic [1:0]          ovr_sel;

    gpio_dv_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .din_async (pin_in),
        .din_sync  (din_sync)
    );

    gpio_dv_state #(
        .NUM_PINS (NUM_PINS),
        .SEL_HI   (SEL_HI),
        .SEL_LO   (SEL_LO)
    ) u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .oe_o  (pin_oe),
        .od_o  (od),
        .sel_o (ovr_sel)
    );

    gpio_dv_rdmux #(
        .NUM_PINS (NUM_PINS),
        .REVISION (REVISION)
    ) u_rdmux (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (reg_addr),
        .oe      (pin_oe),
        .od      (od),
        .din     (din_sync),
        .rdata_o (reg_rdata)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        if (g == OVR_PIN) begin : g_ovr
            gpio_dv_clkovr u_ovr (
                .od_i    (od[g]),
                .sel_i   (ovr_sel),
                .clk_a_i (ovr_clk_a),
                .clk_b_i (ovr_clk_b),
                .pin_o   (pin_out[g])
            );
        end else begin : g_norm
            assign pin_out[g] = od[g];
        end
    end

    // R9
    ovr_first_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_sel == 2'b01) |-> (pin_out[OVR_PIN] == ovr_clk_a));

    // R4
    bank_oe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr[12:4] == PAGE_BANK_OE && int'(reg_addr[3:0]) < NUM_BANKS) |=>
        (pin_oe[{$past(reg_addr[3:0]), 3'b000} +: 8] == $past(reg_wdata)));

endmodule

// File: tb/test_gpio_dual_view.sv
module test_gpio_dual_view;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int         NP   = 128;
    localparam int         OVR  = 40;
    localparam int         SHI  = 87;
    localparam int         SLO  = 88;
    localparam logic [7:0] REV  = 8'h01;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [12:0]   reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic          ovr_clk_a = 1'b0;
    logic          ovr_clk_b = 1'b0;

    always #2.5 clk = ~clk;

    gpio_dual_view #(
        .NUM_PINS (NP), .OVR_PIN (OVR), .SEL_HI (SHI), .SEL_LO (SLO), .REVISION (REV)
    ) i_gpio_dual_view (
        .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .pin_in (pin_in),
        .pin_out (pin_out), .pin_oe (pin_oe), .ovr_clk_a (ovr_clk_a), .ovr_clk_b (ovr_clk_b)
    );

    int vectors = 0;
    int miscompares = 0;
    bit armed = 1'b0;

    task automatic note(input string req, input bit ok, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural reference model
    logic [NP-1:0] m_oe, m_od, m_s1, m_s2;
    logic [7:0]    m_rd;
    int            m_last;

    function automatic logic [7:0] exp_read(input int a);
        if (a < NP)                 return {5'd0, m_s2[a], m_od[a], m_oe[a]};
        if (a >= 'h100 && a < 'h110) return m_s2[(a - 'h100) * 8 +: 8];
        if (a >= 'h110 && a < 'h120) return m_od[(a - 'h110) * 8 +: 8];
        if (a >= 'h120 && a < 'h130) return m_oe[(a - 'h120) * 8 +: 8];
        if (a == 'h130)             return 8'h41;
        if (a == 'h131)             return 8'h00;
        if (a == 'h132)             return REV;
        return 8'h00;
    endfunction

    function automatic logic [NP-1:0] exp_pins();
        logic [NP-1:0] v;
        logic [1:0] s;
        v = m_od;
        s = {m_od[SHI], m_od[SLO]};
        if (s == 2'b01)      v[OVR] = ovr_clk_a;
        else if (s != 2'b00) v[OVR] = ovr_clk_b;
        return v;
    endfunction

    function automatic string rd_req(input int a);
        if (a < NP) return "R3";
        if (a >= 'h100 && a < 'h130) return "R5";
        return "R8";
    endfunction

    always @(posedge clk) begin
        m_s1 <= pin_in;
        m_s2 <= m_s1;
        if (!rst_n) begin
            m_oe   <= '0;
            m_od   <= '0;
            m_rd   <= '0;
            m_last <= 0;
        end else begin
            m_rd   <= exp_read(int'(reg_addr));
            m_last <= int'(reg_addr);
            if (reg_wr) begin
                if (int'(reg_addr) < NP) begin
                    m_oe[reg_addr] <= reg_wdata[0];
                    m_od[reg_addr] <= reg_wdata[1];
                end else if (reg_addr >= 13'h110 && reg_addr < 13'h120) begin
                    for (int k = 0; k < 8; k++) m_od[(int'(reg_addr) - 'h110) * 8 + k] <= reg_wdata[k];
                end else if (reg_addr >= 13'h120 && reg_addr < 13'h130) begin
                    for (int k = 0; k < 8; k++) m_oe[(int'(reg_addr) - 'h120) * 8 + k] <= reg_wdata[k];
                end
            end
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (armed) begin
            logic [NP-1:0] ep;
            ep = exp_pins();
            note("R2 pin_oe", pin_oe === m_oe, pin_oe, m_oe);
            if (pin_out[OVR] !== ep[OVR])
                note("R9 pin_out", 1'b0, pin_out, ep);
            else
                note("R10 pin_out", pin_out === ep, pin_out, ep);
            note({rd_req(m_last), " reg_rdata"}, reg_rdata === m_rd, NP'(reg_rdata), NP'(m_rd));
        end
    end

    task automatic wr(input logic [12:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [12:0] a, output logic [7:0] v);
        reg_wr = 1'b0; reg_addr = a;
        @(posedge clk); #1;
        v = reg_rdata;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        #(200000 * 5);
        miscompares++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0]    v;
        logic [NP-1:0] snap_oe, snap_out;
        logic [31:0]   lfsr;
        lfsr = 32'hACE1_2345;

        @(posedge clk);
        armed = 1'b1;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        note("R1 pin_oe", pin_oe === '0, pin_oe, '0);
        note("R1 pin_out", pin_out === '0, pin_out, '0);
        note("R1 reg_rdata", reg_rdata === 8'h00, NP'(reg_rdata), '0);

        // R2 per-pin write
        wr(13'h005, 8'h03);
        note("R2 oe[5]", pin_oe[5] === 1'b1, NP'(pin_oe[5]), NP'(1));
        note("R2 out[5]", pin_out[5] === 1'b1, NP'(pin_out[5]), NP'(1));
        wr(13'h006, 8'h02);
        note("R2 oe[6]", pin_oe[6] === 1'b0, NP'(pin_oe[6]), NP'(0));
        note("R2 out[6]", pin_out[6] === 1'b1, NP'(pin_out[6]), NP'(1));

        // R3 per-pin read, reserved bits zero
        rd(13'h005, v);
        note("R3 read pin5", v === 8'h03, NP'(v), NP'(8'h03));
        wr(13'h007, 8'hFF);
        rd(13'h007, v);
        note("R3 read pin7", v === 8'h03, NP'(v), NP'(8'h03));

        // R4 bank writes land on pins 8b..8b+7
        wr(13'h112, 8'hA5);
        note("R4 out[23:16]", pin_out[23:16] === 8'hA5, NP'(pin_out[23:16]), NP'(8'hA5));
        wr(13'h121, 8'h3C);
        note("R4 oe[15:8]", pin_oe[15:8] === 8'h3C, NP'(pin_oe[15:8]), NP'(8'h3C));

        // R5 cross-view reads
        rd(13'h012, v);
        note("R5 pin18 via per-pin", v === 8'h02, NP'(v), NP'(8'h02));
        rd(13'h00A, v);
        note("R5 pin10 via per-pin", v === 8'h01, NP'(v), NP'(8'h01));
        rd(13'h112, v);
        note("R5 bank od 2", v === 8'hA5, NP'(v), NP'(8'hA5));
        pin_in[31:24] = 8'h96;
        repeat (3) @(posedge clk);
        #1;
        rd(13'h103, v);
        note("R5 bank in 3", v === 8'h96, NP'(v), NP'(8'h96));

        // R6 synchroniser latency
        reg_addr = 13'h009;
        pin_in[9] = 1'b1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        note("R6 edge k+1", reg_rdata[2] === 1'b0, NP'(reg_rdata[2]), NP'(0));
        @(posedge clk); #1;
        note("R6 edge k+2", reg_rdata[2] === 1'b1, NP'(reg_rdata[2]), NP'(1));

        // R7 ignored writes
        snap_oe = pin_oe;
        snap_out = pin_out;
        wr(13'h101, 8'hFF);
        wr(13'h130, 8'hFF);
        wr(13'h0A0, 8'hFF);
        wr(13'h1FFF, 8'hFF);
        note("R7 oe unchanged", pin_oe === snap_oe, pin_oe, snap_oe);
        note("R7 out unchanged", pin_out === snap_out, pin_out, snap_out);

        // R8 identification and reserved space
        rd(13'h130, v); note("R8 0x130", v === 8'h41, NP'(v), NP'(8'h41));
        rd(13'h131, v); note("R8 0x131", v === 8'h00, NP'(v), NP'(8'h00));
        rd(13'h132, v); note("R8 0x132", v === REV, NP'(v), NP'(REV));
        rd(13'h0A0, v); note("R8 0x0A0", v === 8'h00, NP'(v), NP'(8'h00));
        rd(13'h1FFF, v); note("R8 0x1FFF", v === 8'h00, NP'(v), NP'(8'h00));

        // R9 override selection, R10 other pins untouched
        wr(13'h028, 8'h03);
        wr(13'h058, 8'h02);
        ovr_clk_a = 1'b0; ovr_clk_b = 1'b1; #0.5;
        note("R9 sel01 a=0", pin_out[OVR] === 1'b0, NP'(pin_out[OVR]), NP'(0));
        ovr_clk_a = 1'b1; ovr_clk_b = 1'b0; #0.5;
        note("R9 sel01 a=1", pin_out[OVR] === 1'b1, NP'(pin_out[OVR]), NP'(1));
        wr(13'h057, 8'h02);
        ovr_clk_a = 1'b0; ovr_clk_b = 1'b1; #0.5;
        note("R9 sel11 b=1", pin_out[OVR] === 1'b1, NP'(pin_out[OVR]), NP'(1));
        note("R10 pin 0x57 own data", pin_out[SHI] === 1'b1, NP'(pin_out[SHI]), NP'(1));
        note("R10 oe[0x28] kept", pin_oe[OVR] === 1'b1, NP'(pin_oe[OVR]), NP'(1));
        wr(13'h058, 8'h00);
        ovr_clk_a = 1'b1; ovr_clk_b = 1'b0; #0.5;
        note("R9 sel10 b=0", pin_out[OVR] === 1'b0, NP'(pin_out[OVR]), NP'(0));
        wr(13'h057, 8'h00);
        note("R9 sel00 own data", pin_out[OVR] === 1'b1, NP'(pin_out[OVR]), NP'(1));

        // Mixed traffic against the reference model (all requirements)
        for (int n = 0; n < 4000; n++) begin
            logic [12:0] a;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            case (lfsr[2:0])
                3'd3:    a = 13'h100 + 13'(lfsr[13:8] % 48);
                3'd4:    a = 13'h130 + 13'(lfsr[9:8]);
                3'd5:    a = lfsr[20:8];
                3'd6:    a = lfsr[8] ? 13'h057 : 13'h058;
                default: a = 13'(lfsr[14:8]);
            endcase
            reg_addr  = a;
            reg_wr    = lfsr[3];
            reg_wdata = lfsr[31:24];
            if (lfsr[23]) pin_in[lfsr[22:16]] = ~pin_in[lfsr[22:16]];
            ovr_clk_a = lfsr[4];
            ovr_clk_b = lfsr[5];
            @(posedge clk); #1;
        end
        reg_wr = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        summary();
        $finish;
    end

endmodule